// File: doc/BRIEF.md
# Compact-ISA Register ALU Unit

This block executes the sixteen register-to-register data operations of a 16-bit compressed instruction set. Each cycle with `in_valid` high it takes a 4-bit operation code, the value of the destination register (which is also the first operand), the value of the second register, and the current carry and overflow flags. One clock later it presents the 32-bit result, a destination write strobe and the new N, Z, C and V flags.

The operation set covers bitwise logic, shifts and a rotate by an amount taken from a register, add and subtract with carry, negate, compare, compare-negative, test and a low-word multiply. The register file, instruction fetch and decode sit outside the block. The surrounding core feeds in the register values and the flags, and it writes back whatever the block returns.

Top module: `cisa_reg_alu`

## Requirements
- R1: The logic codes compute the following on first operand A and second operand B: 0 gives A AND B, 1 gives A XOR B, 8 gives A AND B (test), 12 gives A OR B, 14 gives A AND NOT B, and 15 gives NOT B. The result, write strobe and flags appear on the outputs on the clock edge after the one that samples `in_valid` high, and `out_valid` is high in that cycle.
- R2: `wr_en` is high whenever `out_valid` is high, except for codes 8, 10 and 11, which update only the flags.
- R3: The arithmetic codes are: 5 gives A+B+C, 6 gives A+NOT B+C, 9 gives 0+NOT B+1, 10 gives A+NOT B+1 (compare), and 11 gives A+B (compare-negative). C is the carry out of bit 31, which is 1 when a subtract produces no borrow. V is two's-complement overflow.
- R4: Shift and rotate codes take their amount from bits 7:0 of B only. An amount of 0 returns A unchanged and keeps C.
- R5: Code 2 shifts left. For amounts 1 to 31, C is the last bit shifted out. At 32 the result is 0 and C is A bit 0. Above 32 the result and C are both 0.
- R6: Code 3 shifts right logically. For amounts 1 to 31, C is the last bit shifted out. At 32 the result is 0 and C is A bit 31. Above 32 the result and C are both 0.
- R7: Code 4 shifts right arithmetically. For amounts 1 to 31, C is the last bit shifted out. At 32 or more, every result bit and C equal A bit 31.
- R8: Code 7 rotates right by the amount modulo 32. For any nonzero amount, C is bit 31 of the result. A nonzero multiple of 32 returns A.
- R9: Code 13 returns the low 32 bits of A times B and keeps C and V.
- R10: Every code sets N from result bit 31 and Z when the result is zero. The logic, shift, rotate and multiply codes keep V. The logic codes also keep C.
- R11: While `rst_n` is low at a clock edge, every output register clears to zero.
- R12: A cycle with `in_valid` low gives `out_valid` and `wr_en` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| opa | input | 32 | Destination register value, first operand |
| opb | input | 32 | Second register value, also the shift amount source |
| flag_c_in | input | 1 | Current carry flag |
| flag_v_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Write the result to the destination register |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Each shift code is run against amounts of 0, 1, 31, 32 and 33, against 64, against 255, and against a second operand whose low byte is zero but whose upper bits are set. Together these separate the in-range case, the exact-width case and the saturated case, and they show that only the low byte counts as the amount. The arithmetic codes are run on operands chosen to produce a carry, no carry, signed overflow, an equal compare and the negation of 0 and of the most negative value. This confirms the carry-in used by each subtract form and the polarity of carry. A long run of random operands, codes and incoming flags, with idle cycles mixed in, then compares every output on every cycle against a bit-serial behavioural model. Flags that must be kept are checked against incoming values that vary from cycle to cycle.

// File: rtl/ralu_pkg.sv
// Package: operation codes and classification helpers for the register ALU.
// Assumes a 4-bit operation field whose code values are fixed by the ISA.
package ralu_pkg;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_XOR = 4'd1,
        OP_SHL = 4'd2,
        OP_SHR = 4'd3,
        OP_SAR = 4'd4,
        OP_ADC = 4'd5,
        OP_SBC = 4'd6,
        OP_ROR = 4'd7,
        OP_TST = 4'd8,
        OP_NEG = 4'd9,
        OP_CMP = 4'd10,
        OP_CMN = 4'd11,
        OP_ORR = 4'd12,
        OP_MUL = 4'd13,
        OP_BIC = 4'd14,
        OP_MVN = 4'd15
    } alu_op_e;

    // Shifter variant selector.
    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROT   = 2'd3
    } shift_kind_e;

    // Codes that only update flags.
    function automatic logic flags_only(input alu_op_e o);
        return (o == OP_TST) || (o == OP_CMP) || (o == OP_CMN);
    endfunction

    // Codes that go through the adder.
    function automatic logic is_arith(input alu_op_e o);
        return (o == OP_ADC) || (o == OP_SBC) || (o == OP_NEG) ||
               (o == OP_CMP) || (o == OP_CMN);
    endfunction

    // Codes that go through the shifter.
    function automatic logic is_shift(input alu_op_e o);
        return (o == OP_SHL) || (o == OP_SHR) || (o == OP_SAR) || (o == OP_ROR);
    endfunction

endpackage

// File: rtl/ralu_shifter.sv
// Module: register-amount barrel shifter and rotator.
// Does: LSL/LSR/ASR/ROR by an AW-bit amount with carry out of the last bit shifted out.
// Assumes: W is a power of two and AW is wide enough for amounts of W and above.
module ralu_shifter
    import ralu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    input  shift_kind_e   kind,
    input  logic          cin,
    output logic [W-1:0]  res,
    output logic          cout
);
    localparam int RW = $clog2(W);

    logic [2*W-1:0]        left_w;
    logic [2*W-1:0]        right_w;
    logic signed [2*W-1:0] arith_w;
    logic [2*W-1:0]        rot_w;
    logic [RW-1:0]         rot_amt;

    // Purpose: wide shifts whose boundary bit gives the carry, saturating naturally at large amounts.
    always_comb begin
        left_w  = {{W{1'b0}}, val} << amt;
        right_w = {val, {W{1'b0}}} >> amt;
        arith_w = $signed({val, {W{1'b0}}}) >>> amt;
        rot_amt = amt[RW-1:0];
        rot_w   = {val, val} >> rot_amt;
    end

    // Purpose: pick the variant and apply the zero-amount pass-through.
    always_comb begin
        res  = val;
        cout = cin;
        if (amt != '0) begin
            unique case (kind)
                SH_LEFT: begin
                    res  = left_w[W-1:0];
                    cout = left_w[W];
                end
                SH_RIGHT: begin
                    res  = right_w[2*W-1:W];
                    cout = right_w[W-1];
                end
                SH_ARITH: begin
                    res  = arith_w[2*W-1:W];
                    cout = arith_w[W-1];
                end
                default: begin
                    res  = rot_w[W-1:0];
                    cout = rot_w[W-1];
                end
            endcase
        end
    end

endmodule

// File: rtl/ralu_addsub.sv
// Module: W-bit adder with carry in, carry out and signed overflow.
// Does: x + y + ci. Subtraction is obtained upstream by inverting y.
// Assumes: nothing beyond the W-bit operands.
module ralu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co,
    output logic         ov
);
    logic [W:0] full;

    // Purpose: one carry-propagate add and the two arithmetic flags.
    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
        sum  = full[W-1:0];
        co   = full[W];
        ov   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
    end

endmodule

// File: rtl/ralu_logic.sv
// Module: bitwise operations and the low-word multiply.
// Does: AND/TST, XOR, OR, AND-NOT, NOT and the truncated product.
// Assumes: the multiply is allowed to be one combinational product.
module ralu_logic
    import ralu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    // Purpose: select the bitwise or multiply result for the code.
    always_comb begin
        unique case (op)
            OP_XOR:  res = a ^ b;
            OP_ORR:  res = a | b;
            OP_BIC:  res = a & ~b;
            OP_MVN:  res = ~b;
            OP_MUL:  res = a * b;
            default: res = a & b;
        endcase
    end

endmodule

// File: rtl/cisa_reg_alu.sv
// Module: top of the register ALU. Decodes the code, steers the operands to the
// adder, shifter or logic unit, forms the flags, and registers everything for one cycle.
// Assumes: the caller supplies the current C and V and writes back result and flags.
module cisa_reg_alu
    import ralu_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         flag_c_in,
    input  logic         flag_v_in,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_c,
    output logic         flag_v
);
    alu_op_e      op_e;
    alu_op_e      op_q;
    logic [W-1:0] add_x, add_y, add_sum;
    logic         add_ci, add_co, add_ov;
    logic [W-1:0] sh_res, lg_res;
    logic         sh_co;
    shift_kind_e  sh_kind;
    logic [W-1:0] nxt_res;
    logic         nxt_c, nxt_v;

    assign op_e = alu_op_e'(op);

    // Purpose: operand steering for the adder; subtract forms invert the second operand.
    always_comb begin
        add_x  = opa;
        add_y  = opb;
        add_ci = 1'b0;
        unique case (op_e)
            OP_ADC: add_ci = flag_c_in;
            OP_SBC: begin add_y = ~opb; add_ci = flag_c_in; end
            OP_NEG: begin add_x = '0; add_y = ~opb; add_ci = 1'b1; end
            OP_CMP: begin add_y = ~opb; add_ci = 1'b1; end
            default: add_ci = 1'b0;
        endcase
    end

    // Purpose: map the shift codes to a shifter variant.
    always_comb begin
        unique case (op_e)
            OP_SHR:  sh_kind = SH_RIGHT;
            OP_SAR:  sh_kind = SH_ARITH;
            OP_ROR:  sh_kind = SH_ROT;
            default: sh_kind = SH_LEFT;
        endcase
    end

    ralu_addsub #(.W(W)) u_add (
        .x   (add_x),
        .y   (add_y),
        .ci  (add_ci),
        .sum (add_sum),
        .co  (add_co),
        .ov  (add_ov)
    );

    ralu_shifter #(.W(W), .AW(AW)) u_sh (
        .val  (opa),
        .amt  (opb[AW-1:0]),
        .kind (sh_kind),
        .cin  (flag_c_in),
        .res  (sh_res),
        .cout (sh_co)
    );

    ralu_logic #(.W(W)) u_lg (
        .op  (op_e),
        .a   (opa),
        .b   (opb),
        .res (lg_res)
    );

    // Purpose: choose the unit output and the C/V update rule for the code.
    always_comb begin
        if (is_arith(op_e)) begin
            nxt_res = add_sum;
            nxt_c   = add_co;
            nxt_v   = add_ov;
        end else if (is_shift(op_e)) begin
            nxt_res = sh_res;
            nxt_c   = sh_co;
            nxt_v   = flag_v_in;
        end else begin
            nxt_res = lg_res;
            nxt_c   = flag_c_in;
            nxt_v   = flag_v_in;
        end
    end

    // Purpose: output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            wr_en     <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_c    <= 1'b0;
            flag_v    <= 1'b0;
            op_q      <= OP_AND;
        end else begin
            out_valid <= in_valid;
            result    <= nxt_res;
            wr_en     <= in_valid && !flags_only(op_e);
            flag_n    <= nxt_res[W-1];
            flag_z    <= (nxt_res == '0);
            flag_c    <= nxt_c;
            flag_v    <= nxt_v;
            op_q      <= op_e;
        end
    end

    // R2: flag-only codes never write back
    a_r2_no_write_flag_only: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flags_only(op_q)) |-> !wr_en);

    // R12: no write strobe without a valid output
    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !wr_en);

    // R10: non-arithmetic codes keep the incoming V
    a_r10_v_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !is_arith(op_q)) |-> (flag_v == $past(flag_v_in)));

    // R10: Z agrees with the registered result
    a_r10_z_matches: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0)));

    // R4: zero shift amount passes the operand and carry through
    a_r4_zero_amount: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_shift(op_q) && ($past(opb[AW-1:0]) == '0))
        |-> (result == $past(opa) && flag_c == $past(flag_c_in)));

    // R3: negating zero produces no borrow
    a_r3_neg_zero_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_NEG && $past(opb) == '0) |-> (flag_c && flag_z));

endmodule

// File: tb/cisa_reg_alu_tb.sv
module cisa_reg_alu_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] opa, opb;
    logic        flag_c_in, flag_v_in;
    logic        out_valid, wr_en, flag_n, flag_z, flag_c, flag_v;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        e_valid = 0, e_wr = 0, e_n, e_z, e_c, e_v;
    logic [31:0] e_res;
    string       e_tag = "R12";

    always #(CLK_P/2) clk = ~clk;

    cisa_reg_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa), .opb(opb),
        .flag_c_in(flag_c_in), .flag_v_in(flag_v_in), .out_valid(out_valid),
        .result(result), .wr_en(wr_en), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v)
    );

    // Requirement tag for each code.
    function automatic string tag_of(input logic [3:0] o, input logic [31:0] b);
        case (o)
            4'd2:  return (b[7:0] == 0) ? "R4" : "R5";
            4'd3:  return (b[7:0] == 0) ? "R4" : "R6";
            4'd4:  return (b[7:0] == 0) ? "R4" : "R7";
            4'd7:  return (b[7:0] == 0) ? "R4" : "R8";
            4'd5, 4'd6, 4'd9: return "R3";
            4'd10, 4'd11: return "R3/R2";
            4'd13: return "R9";
            4'd8:  return "R1/R2";
            default: return "R1/R10";
        endcase
    endfunction

    // Behavioural model: bit-serial shifts, integer arithmetic.
    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic vi);
        int amt = int'(b[7:0]);
        logic [31:0] r = a;
        logic co = ci, vo = vi;
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        longint s, u;
        case (o)
            4'd0, 4'd8: r = a & b;
            4'd1:  r = a ^ b;
            4'd12: r = a | b;
            4'd14: r = a & ~b;
            4'd15: r = ~b;
            4'd13: r = a * b;
            4'd2: for (int i = 0; i < amt; i++) begin co = r[31]; r = r << 1; end
            4'd3: for (int i = 0; i < amt; i++) begin co = r[0]; r = r >> 1; end
            4'd4: for (int i = 0; i < amt; i++) begin co = r[0]; r = {r[31], r[31:1]}; end
            4'd7: for (int i = 0; i < amt; i++) begin co = r[0]; r = {r[0], r[31:1]}; end
            4'd5, 4'd11: begin
                u = ua + ub + ((o == 4'd5) ? longint'(ci) : 0);
                s = sa + sb + ((o == 4'd5) ? longint'(ci) : 0);
                r = u[31:0]; co = u[32];
                vo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            4'd6, 4'd10, 4'd9: begin
                longint bw = (o == 4'd6) ? longint'(!ci) : 0;
                longint xa = (o == 4'd9) ? 0 : ua;
                longint xs = (o == 4'd9) ? 0 : sa;
                u = xa - ub - bw;
                s = xs - sb - bw;
                r = u[31:0]; co = (xa >= ub + bw);
                vo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            default: r = a;
        endcase
        e_res = r; e_c = co; e_v = vo;
        e_n = r[31]; e_z = (r == 0);
        e_wr = !(o == 4'd8 || o == 4'd10 || o == 4'd11);
    endtask

    // Compare the outputs against the pending expectation.
    task automatic compare();
        checks++;
        if (!e_valid) begin
            if (out_valid !== 1'b0 || wr_en !== 1'b0) begin
                fails++;
                $display("FAIL %s idle: valid=%b wr=%b expected 0 0", e_tag, out_valid, wr_en);
            end
        end else if (out_valid !== 1'b1 || result !== e_res || wr_en !== e_wr ||
                     flag_n !== e_n || flag_z !== e_z || flag_c !== e_c || flag_v !== e_v) begin
            fails++;
            $display("FAIL %s: v=%b res=%h wr=%b nzcv=%b%b%b%b expected v=1 res=%h wr=%b nzcv=%b%b%b%b",
                     e_tag, out_valid, result, wr_en, flag_n, flag_z, flag_c, flag_v,
                     e_res, e_wr, e_n, e_z, e_c, e_v);
        end
    endtask

    // One cycle: check the previous op at this falling edge, then drive the next.
    task automatic step(input logic v, input logic [3:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic ci, input logic vi);
        @(negedge clk);
        compare();
        in_valid = v; op = o; opa = a; opb = b; flag_c_in = ci; flag_v_in = vi;
        e_valid = v;
        if (v) begin
            model(o, a, b, ci, vi);
            e_tag = tag_of(o, b);
        end else begin
            e_tag = "R12";
        end
    endtask

    initial begin
        logic [31:0] pats[3] = '{32'h8000_0001, 32'hF0F0_1234, 32'h7FFF_FFFE};
        int amts[9] = '{0, 1, 5, 31, 32, 33, 64, 255, 256};
        rst_n = 0; in_valid = 1; op = 4'd5; opa = 32'hFFFF_FFFF; opb = 1;
        flag_c_in = 1; flag_v_in = 1;
        repeat (3) @(negedge clk);
        // R11: reset state
        checks++;
        if (out_valid !== 0 || result !== 0 || wr_en !== 0 || flag_n !== 0 ||
            flag_z !== 0 || flag_c !== 0 || flag_v !== 0) begin
            fails++;
            $display("FAIL R11: v=%b res=%h wr=%b nzcv=%b%b%b%b expected all zero",
                     out_valid, result, wr_en, flag_n, flag_z, flag_c, flag_v);
        end
        rst_n = 1; in_valid = 0;
        // R4..R8: shift amount corners
        for (int k = 0; k < 4; k++) begin
            logic [3:0] so = (k == 3) ? 4'd7 : 4'(k + 2);
            foreach (pats[p]) foreach (amts[j]) begin
                logic [31:0] bb = 32'(amts[j]) | ((amts[j] == 256) ? 32'hABCD_0000 : 0);
                step(1, so, pats[p], bb, p[0], !p[0]);
            end
        end
        // R3: arithmetic corners
        step(1, 4'd5, 32'h7FFF_FFFF, 32'h0, 1'b1, 1'b0);
        step(1, 4'd5, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1);
        step(1, 4'd6, 32'h5, 32'h5, 1'b0, 1'b0);
        step(1, 4'd6, 32'h5, 32'h5, 1'b1, 1'b1);
        step(1, 4'd6, 32'h8000_0000, 32'h1, 1'b1, 1'b0);
        step(1, 4'd9, 32'h1234, 32'h0, 1'b0, 1'b1);
        step(1, 4'd9, 32'h1234, 32'h8000_0000, 1'b0, 1'b0);
        step(1, 4'd10, 32'h42, 32'h42, 1'b0, 1'b1);
        step(1, 4'd10, 32'h1, 32'h2, 1'b1, 1'b0);
        step(1, 4'd11, 32'h7FFF_FFFF, 32'h1, 1'b1, 1'b0);
        step(0, 4'd0, 32'h0, 32'h0, 1'b0, 1'b0);
        // R9: multiply
        step(1, 4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1);
        step(1, 4'd13, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b0);
        // R1, R10: every code over random operands and flags
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] b = $urandom;
            if ($urandom_range(1, 0) == 1) b = 32'($urandom_range(40, 0));
            step($urandom_range(7, 0) != 0, 4'($urandom_range(15, 0)), $urandom, b,
                 1'($urandom), 1'($urandom));
        end
        step(0, 4'd0, 32'h0, 32'h0, 1'b0, 1'b0);
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule